// File: doc/BRIEF.md
# Synthesizer Register Programming Sequencer

This block sits on the host side of a fractional-N frequency synthesizer and writes that synthesizer's four control registers over a three-wire serial link made of a serial clock, a data line and a latch-enable strobe. Each register value is a 24-bit word. The word is shifted out most significant bit first, with the data changing while the serial clock is low so that the receiver can sample it on the rising edge. Latch enable goes high after the last bit to transfer the word.

A start pulse picks one of three fixed write orders. The power-up order clears the noise/spur register and then sets it. It then writes the control register with the counter-reset bit set, writes the R-divider and the N-divider, and finally writes the control register again with counter reset cleared. The fast-lock order first loads the wide-bandwidth timer through the R-divider word, and then writes the remaining registers so that the fast-lock switch is routed out and fast lock is armed in the N-divider. The retune order is a single N-divider write with fast lock armed. It is used for frequency jumps once fast lock has been set up.

Register contents come from input ports. The block forces only the bits that the chosen order dictates. The serial clock rate is set at run time by a divider of the system clock.

Top module: `synth_prog_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, sclk, sdata, le and busy are all 0.
- R2: A power-up start sends six words in this order: the clear word; noise_word; ctrl_word with bit 2 forced to 1; rdiv_word with bit 23 forced to 0; ndiv_word unchanged; ctrl_word with bit 2 forced to 0.
- R3: A fast-lock start sends five words in this order: {1, rdiv_word[22:14], fl_timer[11:0], rdiv_word[1:0]}; noise_word; ctrl_word unchanged; {0, 3'b110, rdiv_word[19:0]}; ndiv_word with bit 23 forced to 1.
- R4: A retune start sends exactly one word: ndiv_word with bit 23 forced to 1.
- R5: Each word is 24 bits, most significant bit first. Exactly 24 rising sclk edges occur while le is low, and le rises only after the 24th edge. sdata does not change while sclk is high.
- R6: Each sclk high phase lasts max(sclk_div,1) system clock cycles.
- R7: After each word, le stays high for 4 × max(sclk_div,1) system clock cycles, which is two serial clock periods, and sclk stays low during that time.
- R8: busy rises in the cycle after an accepted start and falls together with le at the end of the last word's latch pulse. Start pulses that arrive while busy is high have no effect.
- R9: When several start inputs are high in the same idle cycle, power-up wins over fast-lock, and fast-lock wins over retune.
- R10: The clear word has bits 23..2 at zero and takes bits 1..0 (the register select) from noise_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pwrup | input | 1 | Pulse: run the power-up order |
| start_fastlock | input | 1 | Pulse: run the fast-lock setup order |
| start_retune | input | 1 | Pulse: run a single N-divider write |
| sclk_div | input | 8 | System clock cycles per sclk half period (0 acts as 1) |
| noise_word | input | 24 | Noise/spur register contents |
| ctrl_word | input | 24 | Control register contents |
| rdiv_word | input | 24 | R-divider register contents, modulus in bits 13..2 |
| ndiv_word | input | 24 | N-divider register contents |
| fl_timer | input | 12 | Fast-lock timer value |
| sclk | output | 1 | Serial clock, idle low |
| sdata | output | 1 | Serial data |
| le | output | 1 | Latch enable, high after each word |
| busy | output | 1 | Order in progress |

## Verification
The hardest conditions to reach from the ports are a start request that lands in the middle of an order, and several start requests that arrive in the same idle cycle. The bench pulses power-up while a retune word is still shifting, and then checks that only one word is latched. It also raises all three starts on one edge and checks that the full six-word power-up order follows. A bench-side receiver rebuilds each word from the rising sclk edges and counts the bits at each le rise. It also measures the high-phase widths for sclk and le at three divider settings, including the zero setting.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;
  localparam int WORD_W = 24;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    SEQ_PWRUP  = 2'd0,
    SEQ_FAST   = 2'd1,
    SEQ_RETUNE = 2'd2
  } seq_e;

  function automatic logic [STEP_W-1:0] seq_last(input seq_e m);
    case (m)
      SEQ_PWRUP: seq_last = 3'd5;
      SEQ_FAST:  seq_last = 3'd4;
      default:   seq_last = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = en && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import synth_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              tick,
  output logic              active,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              done
);
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH} sh_e;

  sh_e               st_q, st_d;
  logic              ph_q, ph_d;
  logic [4:0]        left_q, left_d;
  logic [1:0]        hold_q, hold_d;
  logic [WORD_W-1:0] sr_q, sr_d;

  assign active = (st_q != SH_IDLE);
  assign sclk   = (st_q == SH_SHIFT) && ph_q;
  assign sdata  = (st_q == SH_SHIFT) && sr_q[WORD_W-1];
  assign le     = (st_q == SH_LATCH);
  assign done   = (st_q == SH_LATCH) && tick && (hold_q == 2'd3);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    left_d = left_q;
    hold_d = hold_q;
    sr_d   = sr_q;
    case (st_q)
      SH_IDLE: if (load) begin
        st_d   = SH_SHIFT;
        ph_d   = 1'b0;
        left_d = 5'(WORD_W - 1);
        sr_d   = word;
      end
      SH_SHIFT: if (tick) begin
        if (!ph_q) ph_d = 1'b1;
        else begin
          ph_d = 1'b0;
          if (left_q == '0) begin
            st_d   = SH_LATCH;
            hold_d = '0;
          end else begin
            left_d = left_q - 1'b1;
            sr_d   = {sr_q[WORD_W-2:0], 1'b0};
          end
        end
      end
      SH_LATCH: if (tick) begin
        if (hold_q == 2'd3) st_d = SH_IDLE;
        else                hold_d = hold_q + 1'b1;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      ph_q   <= 1'b0;
      left_q <= '0;
      hold_q <= '0;
      sr_q   <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      left_q <= left_d;
      hold_q <= hold_d;
      sr_q   <= sr_d;
    end
  end

  // R7
  le_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(le && sclk));

  // R5
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import synth_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pwrup,
  input  logic              start_fastlock,
  input  logic              start_retune,
  input  logic              done,
  input  logic [WORD_W-1:0] noise_word,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [WORD_W-1:0] rdiv_word,
  input  logic [WORD_W-1:0] ndiv_word,
  input  logic [11:0]       fl_timer,
  output logic              load,
  output logic [WORD_W-1:0] word,
  output logic              busy
);
  typedef enum logic [1:0] {C_IDLE, C_LOAD, C_WAIT} cst_e;

  cst_e              cst_q, cst_d;
  seq_e              mode_q, mode_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              start_any;

  assign start_any = start_pwrup | start_fastlock | start_retune;
  assign busy      = (cst_q != C_IDLE);
  assign load      = (cst_q == C_LOAD);

  always_comb begin
    word = ndiv_word;
    case (mode_q)
      SEQ_PWRUP: case (step_q)
        3'd0:    word = {22'b0, noise_word[1:0]};
        3'd1:    word = noise_word;
        3'd2:    word = {ctrl_word[23:3], 1'b1, ctrl_word[1:0]};
        3'd3:    word = {1'b0, rdiv_word[22:0]};
        3'd4:    word = ndiv_word;
        default: word = {ctrl_word[23:3], 1'b0, ctrl_word[1:0]};
      endcase
      SEQ_FAST: case (step_q)
        3'd0:    word = {1'b1, rdiv_word[22:14], fl_timer, rdiv_word[1:0]};
        3'd1:    word = noise_word;
        3'd2:    word = ctrl_word;
        3'd3:    word = {1'b0, 3'b110, rdiv_word[19:0]};
        default: word = {1'b1, ndiv_word[22:0]};
      endcase
      default: word = {1'b1, ndiv_word[22:0]};
    endcase
  end

  always_comb begin
    cst_d  = cst_q;
    mode_d = mode_q;
    step_d = step_q;
    case (cst_q)
      C_IDLE: if (start_any) begin
        cst_d  = C_LOAD;
        step_d = '0;
        if (start_pwrup)         mode_d = SEQ_PWRUP;
        else if (start_fastlock) mode_d = SEQ_FAST;
        else                     mode_d = SEQ_RETUNE;
      end
      C_LOAD: cst_d = C_WAIT;
      C_WAIT: if (done) begin
        if (step_q == seq_last(mode_q)) cst_d = C_IDLE;
        else begin
          step_d = step_q + 1'b1;
          cst_d  = C_LOAD;
        end
      end
      default: cst_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst_q  <= C_IDLE;
      mode_q <= SEQ_PWRUP;
      step_q <= '0;
    end else begin
      cst_q  <= cst_d;
      mode_q <= mode_d;
      step_q <= step_d;
    end
  end

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_any) |=> ($stable(mode_q) && (step_q >= $past(step_q))));
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pwrup,
  input  logic             start_fastlock,
  input  logic             start_retune,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic [23:0]      noise_word,
  input  logic [23:0]      ctrl_word,
  input  logic [23:0]      rdiv_word,
  input  logic [23:0]      ndiv_word,
  input  logic [11:0]      fl_timer,
  output logic             sclk,
  output logic             sdata,
  output logic             le,
  output logic             busy
);
  logic              tick, active, load, done;
  logic [WORD_W-1:0] word;

  sclk_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(active), .div(sclk_div), .tick(tick)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_pwrup(start_pwrup), .start_fastlock(start_fastlock),
    .start_retune(start_retune), .done(done),
    .noise_word(noise_word), .ctrl_word(ctrl_word),
    .rdiv_word(rdiv_word), .ndiv_word(ndiv_word), .fl_timer(fl_timer),
    .load(load), .word(word), .busy(busy)
  );

  word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word), .tick(tick),
    .active(active), .sclk(sclk), .sdata(sdata), .le(le), .done(done)
  );

  // R8
  le_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le || sclk) |-> busy);
endmodule

// File: tb/sim_synth_prog_seq.sv
module sim_synth_prog_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic sp, sf, sr;
  logic [7:0]  div;
  logic [23:0] nw, cw, rw, dw;
  logic [11:0] tmr;
  logic sclk, sdata, le, busy;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  synth_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_pwrup(sp), .start_fastlock(sf),
    .start_retune(sr), .sclk_div(div), .noise_word(nw), .ctrl_word(cw),
    .rdiv_word(rw), .ndiv_word(dw), .fl_timer(tmr),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(busy)
  );

  // bench receiver
  logic [23:0] shreg = '0;
  int nbits = 0;
  int ncap = 0;
  logic [23:0] cap [0:7];
  int capbits [0:7];

  always @(posedge sclk) if (!le) begin
    shreg = {shreg[22:0], sdata};
    nbits++;
  end
  always @(posedge le) begin
    if (ncap < 8) begin
      cap[ncap] = shreg;
      capbits[ncap] = nbits;
    end
    ncap++;
    nbits = 0;
  end

  // width monitor
  int hi_run = 0, le_run = 0;
  int hi_min = 1000, hi_max = 0, le_min = 1000, le_max = 0;
  int sdata_chg_hi = 0;
  logic prev_sdata = 1'b0, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (le) le_run++;
    else if (le_run > 0) begin
      if (le_run < le_min) le_min = le_run;
      if (le_run > le_max) le_max = le_run;
      le_run = 0;
    end
    if (sclk && prev_sclk && sdata != prev_sdata) sdata_chg_hi++;
    prev_sclk = sclk;
    prev_sdata = sdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    ncap = 0; nbits = 0;
    hi_min = 1000; hi_max = 0; le_min = 1000; le_max = 0;
    sdata_chg_hi = 0;
  endtask

  task automatic pulse(input logic p, input logic f, input logic r);
    @(negedge clk);
    sp = p; sf = f; sr = r;
    @(negedge clk);
    sp = 0; sf = 0; sr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_bits(input string req, input int n);
    for (int i = 0; i < n && i < 8; i++) chk(req, capbits[i], 24);
  endtask

  task automatic check_timing(input string tag, input int d);
    int h;
    h = (d == 0) ? 1 : d;
    chk({tag, " R6 sclk high min"}, hi_min, h);
    chk({tag, " R6 sclk high max"}, hi_max, h);
    chk({tag, " R7 le width min"}, le_min, 4 * h);
    chk({tag, " R7 le width max"}, le_max, 4 * h);
    chk({tag, " R5 sdata stable"}, sdata_chg_hi, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; sp = 0; sf = 0; sr = 0;
    div = 8'd2;
    nw = 24'h0003C7; cw = 24'h00A5B2; rw = 24'h9ABCD5; dw = 24'hC45679;
    tmr = 12'h208;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {sclk, sdata, le, busy}, 4'b0000);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 after reset", {sclk, sdata, le, busy}, 4'b0000);
  endtask

  task automatic t_pwrup();
    clr_mon();
    div = 8'd2;
    pulse(1, 0, 0);
    chk("R8 busy after start", busy, 1);
    wait_idle();
    chk("R2 word count", ncap, 6);
    chk("R10 clear word", cap[0], {22'b0, nw[1:0]});
    chk("R2 noise", cap[1], nw);
    chk("R2 ctrl rst on", cap[2], {cw[23:3], 1'b1, cw[1:0]});
    chk("R2 rdiv", cap[3], {1'b0, rw[22:0]});
    chk("R2 ndiv", cap[4], dw);
    chk("R2 ctrl rst off", cap[5], {cw[23:3], 1'b0, cw[1:0]});
    check_bits("R5 bits per word", 6);
    check_timing("pwrup", 2);
    chk("R8 idle after order", {busy, le}, 2'b00);
  endtask

  task automatic t_fast();
    clr_mon();
    div = 8'd0;
    pulse(0, 1, 0);
    wait_idle();
    chk("R3 word count", ncap, 5);
    chk("R3 timer word", cap[0], {1'b1, rw[22:14], tmr, rw[1:0]});
    chk("R3 noise", cap[1], nw);
    chk("R3 ctrl", cap[2], cw);
    chk("R3 rdiv mux", cap[3], {1'b0, 3'b110, rw[19:0]});
    chk("R3 ndiv armed", cap[4], {1'b1, dw[22:0]});
    check_bits("R5 bits per word", 5);
    check_timing("fast", 0);
  endtask

  task automatic t_retune();
    clr_mon();
    div = 8'd3;
    dw = 24'h1234FD;
    pulse(0, 0, 1);
    wait_idle();
    chk("R4 word count", ncap, 1);
    chk("R4 ndiv armed", cap[0], {1'b1, dw[22:0]});
    check_bits("R5 bits per word", 1);
    check_timing("retune", 3);
  endtask

  task automatic t_ignore();
    clr_mon();
    div = 8'd1;
    pulse(0, 0, 1);
    repeat (10) @(negedge clk);
    pulse(1, 0, 0);
    repeat (4) @(negedge clk);
    pulse(0, 1, 0);
    wait_idle();
    chk("R8 starts ignored while busy", ncap, 1);
    chk("R8 word kept", cap[0], {1'b1, dw[22:0]});
  endtask

  task automatic t_priority();
    clr_mon();
    div = 8'd1;
    pulse(1, 1, 1);
    wait_idle();
    chk("R9 pwrup wins count", ncap, 6);
    chk("R9 first word clear", cap[0], {22'b0, nw[1:0]});
    clr_mon();
    pulse(0, 1, 1);
    wait_idle();
    chk("R9 fast over retune count", ncap, 5);
    chk("R9 first word timer", cap[0], {1'b1, rw[22:14], tmr, rw[1:0]});
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pwrup();
        t_fast();
        t_retune();
        t_ignore();
        t_priority();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule